// File: doc/BRIEF.md
# LED Matrix Row-Scan Refresh Controller

The controller keeps a 7-row by 96-column LED matrix lit by scanning one row at a time. The slot timer divides time into equal row slots. At the start of each slot the controller blanks every row and loads the new row number into its row-select register. It then streams that row's 96 column bits into an external chain of 8-bit serial-in, parallel-out shift registers. When the last bit is in, it lights the row until the slot ends. Seven slots form one frame, and the frames repeat without end.

Column contents come from a 96-entry by 8-bit column memory. Each entry holds one column of the image, with the bit for row r at bit position r. The top bit is not image data. The read port is asynchronous: `col_data` follows `col_addr` within the same cycle. The serial stream for row r is made by taking bit r of every column byte, starting at column 95 and moving down to column 0. After 96 shift clocks, column k sits at chain stage k, and stage 0 is the stage nearest the controller.

A free-running flash timer can gate the serial data so that the image blinks. The gate applies only while `flash_override` is low.

The slot length, the shift-clock half period and the flash half period are parameters. `TICK_CYCLES` must be at least `192*SHIFT_DIV + 3`.

Top module: `ledrow_refresh`

## Requirements
- R1: A synchronous active-high reset forces all of `row_en` low and holds `ser_clk` low. After reset is released, the first row to light is row 0.
- R2: At most one bit of `row_en` is high at any time. Slot s after reset lights row s mod 7, which drives bit (s mod 7) of `row_en`, so the rows light in the order 0, 1, …, 6 and then repeat.
- R3: `row_en` is all zero in every cycle in which `ser_clk` is high, so the rows are blank before and during shifting.
- R4: Exactly 96 rising edges of `ser_clk` occur in each slot before its row lights. `ser_clk` stays low while a row is lit.
- R5: The first bit shifted in a slot is column 95, and `col_addr` steps down by one per bit. Once the row lights, chain stage k holds bit r of column k, where r is the row being lit.
- R6: `ser_data` holds its value for at least one full clock before each rising edge of `ser_clk`.
- R7: Bit 7 of `col_data` never reaches `ser_data`. A column byte of 8'h80 shifts out as 0 for every row.
- R8: Row-lit onsets are exactly `TICK_CYCLES` cycles apart. Each row is lit for `TICK_CYCLES - 1 - 192*SHIFT_DIV` cycles.
- R9: When `flash_override` is low, the flash phase is high for the first `FLASH_HALF` cycles after reset and then alternates every `FLASH_HALF` cycles. Any bit launched while the phase is low goes out as 0.
- R10: When `flash_override` is high, the shifted bits equal the stored column bits whatever the flash phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flash_override | input | 1 | High disables flash gating |
| col_addr | output | 7 | Column memory read address |
| col_data | input | 8 | Column byte; bit r is row r, bit 7 unused |
| ser_data | output | 1 | Serial column data to the shift-register chain |
| ser_clk | output | 1 | Shift clock to the chain; idles low |
| row_en | output | 7 | One-hot row enables; bit r lights row r |

## Verification
The bench rebuilds the chain contents from the `ser_clk` edges and compares them against the column memory for the expected row. A design that took columns in the wrong order would show a mirrored image. One that picked the wrong bit position would show another row's data or leak bit 7. The bench puts flash frames next to override frames, so a gate applied on the wrong phase, or one that ignores the override, shows up as a whole frame of wrong data. It also checks the slot spacing and the lit length, and applies a reset in the middle of a shift. A blank released early, an off-by-one in the bit count, or a row counter that does not restart at row 0 would each fail these checks.

// File: rtl/ledscan_pkg.sv
`timescale 1ns/1ps
package ledscan_pkg;

    // Per-slot sequencer phases
    typedef enum logic [1:0] {
        SQ_BLANK,
        SQ_LOAD,
        SQ_SHIFT,
        SQ_SHOW
    } seq_state_e;

    // Row-select register: blank flag plus 3-bit row code, loaded together
    typedef struct packed {
        logic       blank;
        logic [2:0] code;
    } rowsel_t;

    // Next row number, wrapping after the last row
    function automatic logic [2:0] next_row(input logic [2:0] cur, input int unsigned nrows);
        if (int'(cur) >= int'(nrows) - 1)
            return 3'd0;
        return cur + 3'd1;
    endfunction

endpackage

// File: rtl/slot_timer.sv
`timescale 1ns/1ps
module slot_timer #(
    parameter int unsigned TICK_CYCLES = 47500
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int unsigned CW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + CW'(1);
    end

    assign tick = (cnt == LAST);

    // R8
    slot_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> (cnt == '0));

endmodule

// File: rtl/flash_gen.sv
`timescale 1ns/1ps
module flash_gen #(
    parameter int unsigned FLASH_HALF = 25000000
) (
    input  logic clk,
    input  logic rst,
    output logic gate_open
);
    localparam int unsigned FW = (FLASH_HALF > 1) ? $clog2(FLASH_HALF) : 1;
    localparam logic [FW-1:0] LAST = FW'(FLASH_HALF - 1);

    logic [FW-1:0] fcnt;
    logic          phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            fcnt  <= '0;
            phase <= 1'b1;
        end else if (fcnt == LAST) begin
            fcnt  <= '0;
            phase <= ~phase;
        end else begin
            fcnt  <= fcnt + FW'(1);
        end
    end

    assign gate_open = phase;

    // R9
    flash_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (fcnt != '0) |-> $stable(phase));

endmodule

// File: rtl/row_decode.sv
`timescale 1ns/1ps
module row_decode
    import ledscan_pkg::*;
#(
    parameter int unsigned N_ROWS = 7
) (
    input  rowsel_t           sel,
    output logic [N_ROWS-1:0] row_en
);
    for (genvar i = 0; i < N_ROWS; i++) begin : g_row
        assign row_en[i] = !sel.blank && (sel.code == 3'(i));
    end
endmodule

// File: rtl/shift_seq.sv
`timescale 1ns/1ps
module shift_seq
    import ledscan_pkg::*;
#(
    parameter int unsigned N_ROWS    = 7,
    parameter int unsigned N_COLS    = 96,
    parameter int unsigned COL_BITS  = 8,
    parameter int unsigned SHIFT_DIV = 80
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        tick,
    input  logic                        gate_open,
    input  logic                        flash_override,
    input  logic [COL_BITS-1:0]         col_data,
    output logic [$clog2(N_COLS)-1:0]   col_addr,
    output logic                        ser_data,
    output logic                        ser_clk,
    output rowsel_t                     rowsel
);
    localparam int unsigned COLW = $clog2(N_COLS);
    localparam int unsigned DIVW = $clog2(2 * SHIFT_DIV);
    localparam logic [COLW-1:0] LASTCOL  = COLW'(N_COLS - 1);
    localparam logic [DIVW-1:0] DIV_RISE = DIVW'(SHIFT_DIV - 1);
    localparam logic [DIVW-1:0] DIV_END  = DIVW'(2 * SHIFT_DIV - 1);

    seq_state_e      state;
    logic [2:0]      slot_row;
    logic [DIVW-1:0] div_cnt;
    logic [COLW-1:0] bit_idx;
    logic            bit_raw;
    logic            pick;

    assign bit_raw = col_data[slot_row];
    assign pick    = bit_raw & (gate_open | flash_override);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SQ_BLANK;
            slot_row <= 3'd0;
            rowsel   <= '{blank: 1'b1, code: 3'd0};
            div_cnt  <= '0;
            bit_idx  <= '0;
            col_addr <= LASTCOL;
            ser_clk  <= 1'b0;
            ser_data <= 1'b0;
        end else if (tick) begin
            state    <= SQ_BLANK;
            slot_row <= next_row(slot_row, N_ROWS);
        end else begin
            unique case (state)
                SQ_BLANK: begin
                    rowsel.blank <= 1'b1;
                    col_addr     <= LASTCOL;
                    bit_idx      <= '0;
                    div_cnt      <= '0;
                    ser_clk      <= 1'b0;
                    state        <= SQ_LOAD;
                end
                SQ_LOAD: begin
                    rowsel.code <= slot_row;
                    ser_data    <= pick;
                    state       <= SQ_SHIFT;
                end
                SQ_SHIFT: begin
                    if (div_cnt == DIV_RISE) begin
                        ser_clk <= 1'b1;
                        if (bit_idx != LASTCOL)
                            col_addr <= col_addr - COLW'(1);
                        div_cnt <= div_cnt + DIVW'(1);
                    end else if (div_cnt == DIV_END) begin
                        ser_clk <= 1'b0;
                        div_cnt <= '0;
                        if (bit_idx == LASTCOL) begin
                            state        <= SQ_SHOW;
                            rowsel.blank <= 1'b0;
                            ser_data     <= 1'b0;
                        end else begin
                            bit_idx  <= bit_idx + COLW'(1);
                            ser_data <= pick;
                        end
                    end else begin
                        div_cnt <= div_cnt + DIVW'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // R3
    blank_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_SHIFT) |-> rowsel.blank);

    // R5
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(ser_clk) && bit_idx != LASTCOL) |-> (col_addr == $past(col_addr) - COLW'(1)));

    // R6
    data_setup_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ser_clk) |-> $stable(ser_data));

    // R2
    code_range_chk: assert property (@(posedge clk) disable iff (rst)
        int'(rowsel.code) < int'(N_ROWS));

endmodule

// File: rtl/ledrow_refresh.sv
`timescale 1ns/1ps
module ledrow_refresh
    import ledscan_pkg::*;
#(
    parameter int unsigned N_ROWS      = 7,
    parameter int unsigned N_COLS      = 96,
    parameter int unsigned COL_BITS    = 8,
    parameter int unsigned TICK_CYCLES = 47500,
    parameter int unsigned SHIFT_DIV   = 80,
    parameter int unsigned FLASH_HALF  = 25000000
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      flash_override,
    output logic [$clog2(N_COLS)-1:0] col_addr,
    input  logic [COL_BITS-1:0]       col_data,
    output logic                      ser_data,
    output logic                      ser_clk,
    output logic [N_ROWS-1:0]         row_en
);
    logic    tick;
    logic    gate_open;
    rowsel_t rowsel;

    slot_timer #(.TICK_CYCLES(TICK_CYCLES)) u_timer (
        .clk (clk),
        .rst (rst),
        .tick(tick)
    );

    flash_gen #(.FLASH_HALF(FLASH_HALF)) u_flash (
        .clk      (clk),
        .rst      (rst),
        .gate_open(gate_open)
    );

    shift_seq #(
        .N_ROWS   (N_ROWS),
        .N_COLS   (N_COLS),
        .COL_BITS (COL_BITS),
        .SHIFT_DIV(SHIFT_DIV)
    ) u_seq (
        .clk           (clk),
        .rst           (rst),
        .tick          (tick),
        .gate_open     (gate_open),
        .flash_override(flash_override),
        .col_data      (col_data),
        .col_addr      (col_addr),
        .ser_data      (ser_data),
        .ser_clk       (ser_clk),
        .rowsel        (rowsel)
    );

    row_decode #(.N_ROWS(N_ROWS)) u_dec (
        .sel   (rowsel),
        .row_en(row_en)
    );

    // R2
    rows_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(row_en));

    // R3
    dark_while_clk_chk: assert property (@(posedge clk) disable iff (rst)
        ser_clk |-> (row_en == '0));

endmodule

// File: tb/ledrow_refresh_test.sv
`timescale 1ns/1ps
module ledrow_refresh_test;
    localparam int NR   = 7;
    localparam int NC   = 96;
    localparam int TICK = 430;
    localparam int DIV  = 2;
    localparam int FH   = 7 * TICK;
    localparam int LIT  = TICK - 1 - 2 * NC * DIV;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       flash_override = 1'b0;
    logic [6:0] col_addr;
    logic [7:0] col_data;
    logic       ser_data;
    logic       ser_clk;
    logic [NR-1:0] row_en;

    logic [7:0] mem [NC];
    assign col_data = mem[col_addr];

    ledrow_refresh #(
        .N_ROWS(NR), .N_COLS(NC), .COL_BITS(8),
        .TICK_CYCLES(TICK), .SHIFT_DIV(DIV), .FLASH_HALF(FH)
    ) uut (
        .clk(clk), .rst(rst), .flash_override(flash_override),
        .col_addr(col_addr), .col_data(col_data),
        .ser_data(ser_data), .ser_clk(ser_clk), .row_en(row_en)
    );

    always #2.5 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [NC-1:0] exp_chain(input int r, input bit g);
        logic [NC-1:0] v;
        for (int k = 0; k < NC; k++) v[k] = mem[k][r] & g;
        return v;
    endfunction

    // Monitor state
    int            slot = 0;
    int            rises = 0;
    int            lit_len = 0;
    longint        cyc = 0;
    longint        last_onset = 0;
    logic          p_sclk = 1'b0;
    logic          p_sdat = 1'b0;
    logic [NR-1:0] p_row = '0;
    logic [NC-1:0] chain = '0;

    always @(negedge clk) begin
        if (rst) begin
            slot = 0; rises = 0; lit_len = 0; cyc = 0;
            p_sclk = 1'b0; p_sdat = 1'b0; p_row = '0;
        end else begin
            cyc++;
            if (ser_clk && !p_sclk) begin
                rises++;
                chain = {chain[NC-2:0], ser_data};
                check(ser_data == p_sdat, "R6", "data changed at shift edge", ser_data, p_sdat);
            end
            if (ser_clk)
                check(row_en == '0, "R3", "row lit while shifting", row_en, 0);
            if (row_en != '0 && p_row == '0) begin
                int  r;
                bit  g;
                logic [NC-1:0] e;
                r = slot % NR;
                g = flash_override || (((slot / NR) % 2) == 0);
                e = exp_chain(r, g);
                check(rises == NC, "R4", "bits shifted before lighting", rises, NC);
                check(row_en == NR'(1 << r), (slot == 0) ? "R1" : "R2", "row order", row_en, 1 << r);
                if (flash_override)
                    check(chain == e, "R10", "chain with override", chain[63:0], e[63:0]);
                else if (!g)
                    check(chain == e, "R9", "chain in flash-off frame", chain[63:0], e[63:0]);
                else
                    check(chain == e, "R5", "chain contents", chain[63:0], e[63:0]);
                if (slot > 0) begin
                    check(cyc - last_onset == TICK, "R8", "slot spacing", cyc - last_onset, TICK);
                    check(lit_len == LIT, "R8", "lit length", lit_len, LIT);
                end
                last_onset = cyc;
                rises = 0;
                lit_len = 0;
                slot++;
            end
            if (row_en != '0) begin
                lit_len++;
                if (ser_clk) check(1'b0, "R4", "shift clock high while lit", 1, 0);
            end
            p_sclk = ser_clk;
            p_sdat = ser_data;
            p_row  = row_en;
        end
    end

    // Wait for the next row onset, then act 1 ns after the sampling edge
    task automatic wait_onset();
        int s0;
        s0 = slot;
        while (slot == s0) @(negedge clk);
        #1;
    endtask

    task automatic randomize_mem();
        for (int k = 0; k < NC; k++) mem[k] = 8'($urandom);
    endtask

    task automatic run_slots(input int n, input bit rand_ovr);
        for (int i = 0; i < n; i++) begin
            wait_onset();
            if (slot == 10) begin
                for (int k = 0; k < NC; k++) mem[k] = 8'h80;       // R7 directed
            end else if (slot == 11) begin
                for (int k = 0; k < NC; k++) mem[k] = (k % 2 == 0) ? 8'hFF : 8'h00;
            end else if ($urandom % 2 == 0) begin
                randomize_mem();
            end
            if (slot % NR == 0) begin
                if (rand_ovr) flash_override = 1'($urandom);
                else          flash_override = (slot / NR == 2);
            end
        end
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        randomize_mem();
        repeat (4) @(negedge clk);
        check(row_en == '0, "R1", "rows in reset", row_en, 0);
        check(ser_clk == 1'b0, "R1", "shift clock in reset", ser_clk, 0);
        rst = 1'b0;
        run_slots(28, 1'b0);        // frames 0,1 flash; frame 2 override; frame 3 flash
        // Reset in the middle of a shift
        while (!ser_clk) @(negedge clk);
        repeat (7) @(negedge clk);
        rst = 1'b1;
        flash_override = 1'b0;
        repeat (3) @(negedge clk);
        check(row_en == '0, "R1", "rows after mid-run reset", row_en, 0);
        check(ser_clk == 1'b0, "R1", "clock after mid-run reset", ser_clk, 0);
        rst = 1'b0;
        run_slots(15, 1'b1);
        repeat (5) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(5 * 150000);
        if (!done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule